// File: doc/BRIEF.md
# Fixed-Point Rounding Right Shifter

This block is a purely combinational primitive that divides a fixed-point value by a power of two and decides whether the truncated quotient must be bumped up by one least-significant unit. Averaging adders, scaling shifts and narrowing clips all need the same rounding step, so they share this unit. The caller supplies the value, a shift amount, one of four rounding modes and a flag that picks an arithmetic or a logical shift. The unit returns the rounding increment on its own and the rounded quotient. The quotient is the shifted value plus the increment, and it wraps modulo 2^DATA_W.

The increment is built from three things: the new least-significant bit, the bit just below it (the guard bit), and the OR of the discarded bits below the guard bit (the sticky bit). The positions of all three move with the shift amount. Masks derived from the shift amount select them, so the unit contains no loops and no state. A shift of zero, or a shift wider than the data path, never rounds.

Top module: `rsh_round_shift`

## Requirements
- R1: When the shift amount is 0, or greater than DATA_W, the increment is 0. A shift of 0 returns the input value unchanged.
- R2: Mode code 0 (nearest, ties upward) makes the increment equal to the guard bit, which is input bit shift-1.
- R3: Mode code 1 (nearest, ties to even) makes the increment the guard bit AND (the OR of input bits below shift-1, OR the new LSB). At a shift of 1 no lower bits exist, so the increment is the guard bit AND the new LSB.
- R4: Mode code 2 (truncate) always gives an increment of 0.
- R5: Mode code 3 (jam to odd) makes the increment NOT(new LSB) AND (the OR of the low `shift` input bits). A jammed increment always leaves bit 0 of the result set.
- R6: At a shift of exactly DATA_W, the new LSB is 0 for a logical shift and the input sign bit for an arithmetic shift, and all DATA_W input bits count as discarded.
- R7: For shifts below DATA_W, the result equals the input shifted right by the shift amount plus the increment, modulo 2^DATA_W. The shift is arithmetic when the signed select is 1 and logical when it is 0.
- R8: For shifts of DATA_W or more, the shifted part is all copies of the sign bit for an arithmetic shift and all zeros for a logical shift, before the increment is added.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| value_i | input | DATA_W | Value to shift and round |
| shamt_i | input | SHAMT_W | Right shift amount, 0 up to 2^SHAMT_W-1 |
| rmode_i | input | 2 | Rounding mode: 0 nearest-up, 1 nearest-even, 2 truncate, 3 jam-to-odd |
| signed_i | input | 1 | 1 selects an arithmetic shift, 0 a logical shift |
| round_inc_o | output | 1 | Rounding increment added to the shifted value |
| result_o | output | DATA_W | Shifted value plus increment, modulo 2^DATA_W |

## Verification
Some properties are checked on every evaluation of the inputs: no increment outside the shift window or in truncate mode, pass-through at a zero shift, an odd result whenever jamming adds one, and the sticky bit below the guard being set only when the whole discarded field is nonzero. The exact increment for each mode, the tie behaviour of nearest-even, and the sign fill at and beyond the full width can only be shown by the bench. It compares both outputs against an arithmetic model over an exhaustive sweep of an 8-bit configuration, plus directed and random 64-bit corner vectors.

// File: rtl/rsh_pkg.sv
package rsh_pkg;
  typedef enum logic [1:0] {
    RM_NEAR_UP   = 2'd0,
    RM_NEAR_EVEN = 2'd1,
    RM_TRUNC     = 2'd2,
    RM_JAM_ODD   = 2'd3
  } rmode_e;
endpackage

// File: rtl/rsh_barrel.sv
// Logarithmic right shifter with a selectable fill bit; saturates at >= DATA_W.
module rsh_barrel #(
  parameter int DATA_W  = 64,
  parameter int SHAMT_W = 7
) (
  input  logic [DATA_W-1:0]  value_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic               fill_i,
  output logic [DATA_W-1:0]  shifted_o
);
  localparam int LOG_W = $clog2(DATA_W);

  logic [DATA_W-1:0] stage [LOG_W+1];
  logic              too_far;

  assign stage[0] = value_i;

  for (genvar k = 0; k < LOG_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stage[k+1] = shamt_i[k] ? {{STEP{fill_i}}, stage[k][DATA_W-1:STEP]}
                                   : stage[k];
  end

  assign too_far   = |shamt_i[SHAMT_W-1:LOG_W];
  assign shifted_o = too_far ? {DATA_W{fill_i}} : stage[LOG_W];
endmodule

// File: rtl/rsh_sticky.sv
// Guard bit and sticky ORs selected by shift-amount-derived masks.
module rsh_sticky #(
  parameter int DATA_W  = 64,
  parameter int SHAMT_W = 7
) (
  input  logic [DATA_W-1:0]  value_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  output logic               guard_o,
  output logic               sticky_below_o,
  output logic               sticky_all_o
);
  logic [DATA_W-1:0] low_mask;
  logic [DATA_W-1:0] below_mask;
  logic [DATA_W-1:0] guard_mask;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    localparam logic [SHAMT_W-1:0] IDX  = SHAMT_W'(i);
    localparam logic [SHAMT_W-1:0] IDX1 = SHAMT_W'(i + 1);
    assign low_mask[i]   = shamt_i > IDX;
    assign below_mask[i] = shamt_i > IDX1;
    assign guard_mask[i] = shamt_i == IDX1;
  end

  assign guard_o        = |(value_i & guard_mask);
  assign sticky_below_o = |(value_i & below_mask);
  assign sticky_all_o   = |(value_i & low_mask);

  always_comb begin
    if (sticky_below_o) begin
      assert_sticky_nested_R3: assert (sticky_all_o)
        else $error("sticky below guard set while discarded field is zero");
    end
  end
endmodule

// File: rtl/rsh_round_decide.sv
// Chooses the rounding increment for the selected mode.
module rsh_round_decide
  import rsh_pkg::*;
(
  input  logic [1:0] rmode_i,
  input  logic       active_i,
  input  logic       lsb_i,
  input  logic       guard_i,
  input  logic       sticky_below_i,
  input  logic       sticky_all_i,
  output logic       inc_o
);
  rmode_e mode;
  logic   raw_inc;

  assign mode = rmode_e'(rmode_i);

  always_comb begin
    unique case (mode)
      RM_NEAR_UP:   raw_inc = guard_i;
      RM_NEAR_EVEN: raw_inc = guard_i & (sticky_below_i | lsb_i);
      RM_TRUNC:     raw_inc = 1'b0;
      RM_JAM_ODD:   raw_inc = ~lsb_i & sticky_all_i;
      default:      raw_inc = 1'b0;
    endcase
  end

  assign inc_o = active_i & raw_inc;
endmodule

// File: rtl/rsh_round_shift.sv
module rsh_round_shift #(
  parameter int DATA_W  = 64,
  parameter int SHAMT_W = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0]  value_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic [1:0]         rmode_i,
  input  logic               signed_i,
  output logic               round_inc_o,
  output logic [DATA_W-1:0]  result_o
);
  localparam logic [SHAMT_W-1:0] FULL_AMT = SHAMT_W'(DATA_W);

  logic [DATA_W-1:0] shifted;
  logic              fill_bit;
  logic              guard;
  logic              sticky_below;
  logic              sticky_all;
  logic              in_window;

  assign fill_bit  = signed_i & value_i[DATA_W-1];
  assign in_window = (shamt_i != '0) && (shamt_i <= FULL_AMT);

  rsh_barrel #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_barrel (
    .value_i   (value_i),
    .shamt_i   (shamt_i),
    .fill_i    (fill_bit),
    .shifted_o (shifted)
  );

  rsh_sticky #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_sticky (
    .value_i        (value_i),
    .shamt_i        (shamt_i),
    .guard_o        (guard),
    .sticky_below_o (sticky_below),
    .sticky_all_o   (sticky_all)
  );

  // The new LSB is bit 0 of the shifted value; at a full-width shift it is the fill bit.
  rsh_round_decide u_decide (
    .rmode_i        (rmode_i),
    .active_i       (in_window),
    .lsb_i          (shifted[0]),
    .guard_i        (guard),
    .sticky_below_i (sticky_below),
    .sticky_all_i   (sticky_all),
    .inc_o          (round_inc_o)
  );

  assign result_o = shifted + DATA_W'(round_inc_o);

  always_comb begin
    if (shamt_i == '0 || shamt_i > FULL_AMT) begin
      assert_no_inc_outside_R1: assert (!round_inc_o)
        else $error("increment raised outside the shift window");
    end
    if (shamt_i == '0) begin
      assert_zero_shift_passthru_R1: assert (result_o == value_i)
        else $error("zero shift altered the value");
    end
    if (rmode_i == 2'd2) begin
      assert_trunc_no_inc_R4: assert (!round_inc_o)
        else $error("truncate mode raised an increment");
    end
    if (rmode_i == 2'd3 && round_inc_o) begin
      assert_jam_odd_lsb_R5: assert (result_o[0])
        else $error("jam-to-odd increment left an even result");
    end
  end
endmodule

// File: tb/rsh_round_shift_test.sv
module rsh_round_shift_test;
  logic clk;
  logic rst_n;
  int   n_tests;
  int   n_fail;
  bit   done;

  // Full-width instance
  logic [63:0] v64;
  logic [6:0]  s64;
  logic [1:0]  m64;
  logic        sg64;
  logic        inc64;
  logic [63:0] r64;

  // Small instance for exhaustive sweep
  logic [7:0]  v8;
  logic [3:0]  s8;
  logic [1:0]  m8;
  logic        sg8;
  logic        inc8;
  logic [7:0]  r8;

  rsh_round_shift uut (
    .value_i(v64), .shamt_i(s64), .rmode_i(m64), .signed_i(sg64),
    .round_inc_o(inc64), .result_o(r64)
  );

  rsh_round_shift #(.DATA_W(8), .SHAMT_W(4)) uut_small (
    .value_i(v8), .shamt_i(s8), .rmode_i(m8), .signed_i(sg8),
    .round_inc_o(inc8), .result_o(r8)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    finish_run();
  end

  // Arithmetic model: returns {inc, result} with result masked to w bits.
  function automatic logic [64:0] model(logic [63:0] v, int s, int m, bit sg, int w);
    logic [127:0] ext, q, frac, half;
    logic [63:0]  res;
    bit inc, d;
    for (int i = 0; i < 128; i++)
      ext[i] = (i < w) ? v[i] : (sg ? v[w-1] : 1'b0);
    q = sg ? 128'($signed(ext) >>> s) : (ext >> s);
    d = q[0];
    inc = 1'b0;
    if (s != 0 && s <= w) begin
      frac = ext & ((128'd1 << s) - 128'd1);
      half = 128'd1 << (s - 1);
      case (m)
        0: inc = (frac >= half);
        1: inc = (frac > half) || (frac == half && d);
        2: inc = 1'b0;
        default: inc = !d && (frac != 0);
      endcase
    end
    res = q[63:0] + 64'(inc);
    if (w < 64) res = res & ((64'd1 << w) - 64'd1);
    return {inc, res};
  endfunction

  function automatic string inc_tag(int s, int m, int w);
    if (s == 0 || s > w) return "R1";
    if (m == 2) return "R4";
    if (s == w) return "R6";
    case (m)
      0: return "R2";
      1: return "R3";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp,
                       logic [63:0] v, int s, int m, bit sg);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h (v=%h s=%0d mode=%0d sg=%0b)",
               tag, what, act, exp, v, s, m, sg);
    end
  endtask

  task automatic run64(logic [63:0] v, int s, int m, bit sg);
    logic [64:0] e;
    @(posedge clk);
    v64 = v; s64 = 7'(s); m64 = 2'(m); sg64 = sg;
    @(negedge clk);
    e = model(v, s, m, sg, 64);
    check(inc_tag(s, m, 64), "inc", 64'(inc64), 64'(e[64]), v, s, m, sg);
    check((s >= 64) ? "R8" : "R7", "result", r64, e[63:0], v, s, m, sg);
  endtask

  task automatic run8(logic [7:0] v, int s, int m, bit sg);
    logic [64:0] e;
    @(posedge clk);
    v8 = v; s8 = 4'(s); m8 = 2'(m); sg8 = sg;
    @(negedge clk);
    e = model(64'(v), s, m, sg, 8);
    check(inc_tag(s, m, 8), "inc8", 64'(inc8), 64'(e[64]), 64'(v), s, m, sg);
    check((s >= 8) ? "R8" : "R7", "result8", 64'(r8), e[63:0], 64'(v), s, m, sg);
  endtask

  initial begin
    logic [63:0] corners [8];
    int          shifts  [7];
    n_tests = 0; n_fail = 0; done = 1'b0;
    v64 = '0; s64 = '0; m64 = '0; sg64 = 1'b0;
    v8 = '0; s8 = '0; m8 = '0; sg8 = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Reset state: zero inputs give zero outputs (R1 zero shift)
    check("R1", "reset inc", 64'(inc64), 64'd0, v64, 0, 0, 0);
    check("R1", "reset result", r64, 64'd0, v64, 0, 0, 0);
    rst_n = 1'b1;

    // Exhaustive sweep of the 8-bit configuration: R1..R8
    for (int s = 0; s < 16; s++)
      for (int m = 0; m < 4; m++)
        for (int sg = 0; sg < 2; sg++)
          for (int v = 0; v < 256; v++)
            run8(8'(v), s, m, sg[0]);

    // Directed 64-bit corners around the shift window: R1, R6, R8
    corners[0] = 64'h0;
    corners[1] = 64'h1;
    corners[2] = 64'hFFFF_FFFF_FFFF_FFFF;
    corners[3] = 64'h8000_0000_0000_0000;
    corners[4] = 64'h7FFF_FFFF_FFFF_FFFF;
    corners[5] = 64'h8000_0000_0000_0001;
    corners[6] = 64'h0000_0000_0000_0003;
    corners[7] = 64'hAAAA_AAAA_AAAA_AAAA;
    shifts = '{0, 1, 2, 63, 64, 65, 127};
    for (int c = 0; c < 8; c++)
      for (int k = 0; k < 7; k++)
        for (int m = 0; m < 4; m++)
          for (int sg = 0; sg < 2; sg++)
            run64(corners[c], shifts[k], m, sg[0]);

    // Random 64-bit vectors: R2, R3, R5, R7
    for (int n = 0; n < 3000; n++)
      run64({$urandom, $urandom}, int'($urandom_range(0, 127)),
            int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));

    finish_run();
  end
endmodule